// File: doc/BRIEF.md
# Grouped Peripheral Interrupt Expander

This block gathers a wide set of peripheral interrupt lines, arranged in groups of eight sources, and folds each group onto a single CPU interrupt line. Each source has a flag bit and an enable bit. A pulse on a source's line sets its flag, whatever the enable bit holds.

A group raises its CPU line when two things are true: some source in the group is both flagged and enabled, and the group's lockout bit is clear. At the moment it raises the line, the group also sets its lockout bit. That bit keeps the group silent until software writes a one to clear it.

When the CPU takes the interrupt, it pulses a fetch strobe together with the group number. In the same cycle the block returns a vector index made of the group and the winning source. It clears the flag of that source at the following clock edge. A small write port replaces a group's enable byte and clears lockout bits. A read port shows any group's flags, enables and lockout bit.

Top module: `grp_irq_expander`

## Requirements
- R1: After reset every flag, enable and lockout bit is 0 and every `cpu_irq` bit is 0.
- R2: A one on `irq_pulse[g*8+s]` sets the flag of source s in group g at the next clock edge, whatever its enable bit holds. The flag stays set until a fetch returns that source.
- R3: A group never raises `cpu_irq` while none of its sources is both flagged and enabled.
- R4: When a group raises `cpu_irq`, its lockout bit becomes 1 at the same edge. While the lockout bit is 1 the group forwards no further request.
- R5: A one in `ack_clr[g]` clears group g's lockout bit at the next edge. Zero bits in `ack_clr` leave the other groups' lockout bits unchanged.
- R6: `cpu_irq[g]` goes high at the clock edge after a flagged and enabled source exists with the lockout bit at 0. It stays high until a fetch strobe for group g.
- R7: During a fetch, `vec_out` = {`fetch_grp`[3:0], source[2:0]}. The source is the lowest-numbered one that is both flagged and enabled, so source 0 has the highest priority.
- R8: If no source in the fetched group is both flagged and enabled, `vec_out` carries source 0 of that group, and source 0's flag is cleared.
- R9: A fetch clears only the flag of the returned source. The other flags of the group are kept.
- R10: A pulse arriving in the same cycle as a fetch clear of the same flag leaves that flag set.
- R11: An enable write (`en_we`) replaces the whole enable byte of group `en_grp` with `en_data`. Other groups' enables do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_pulse | input | 96 | Peripheral interrupt pulses; bit g*8+s is group g, source s |
| en_we | input | 1 | Enable byte write strobe |
| en_grp | input | 4 | Group addressed by the enable write |
| en_data | input | 8 | New enable byte |
| ack_clr | input | 12 | Write-one-to-clear for the group lockout bits |
| fetch_stb | input | 1 | CPU vector fetch strobe |
| fetch_grp | input | 4 | Group being fetched |
| vec_out | output | 7 | Vector index {group, source}, valid during a fetch |
| cpu_irq | output | 12 | One request level per group |
| rd_grp | input | 4 | Group shown on the read port |
| rd_flags | output | 8 | Flags of group `rd_grp` |
| rd_enables | output | 8 | Enables of group `rd_grp` |
| rd_ack | output | 1 | Lockout bit of group `rd_grp` |

## Verification
Inside each group, properties check the following on every cycle:
- a request only rises from a live source with the lockout bit clear;
- the lockout bit rises with the request, and a raised request holds until a fetch;
- the picked source has no higher-priority live neighbour;
- a fetch clears exactly the returned flag, and pulses always win over clears.

Some behaviours can only be shown by the bench scenarios:
- the exact vector values for mixed priorities and the fallback case;
- re-arming after software clears a lockout;
- that writes to one group's enables or lockout bit leave the other groups alone.

// File: rtl/pie_pkg.sv
package pie_pkg;
  localparam int unsigned DEF_GROUPS = 12;
  localparam int unsigned DEF_SRCS   = 8;
  localparam int unsigned SYNC_DEPTH = 2;
endpackage

// File: rtl/pie_rst_sync.sv
module pie_rst_sync #(
  parameter int unsigned DEPTH = pie_pkg::SYNC_DEPTH
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [DEPTH-1:0] pipe_q;
  logic [DEPTH-1:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[DEPTH-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  assign rst_sync_n = pipe_q[DEPTH-1];
endmodule

// File: rtl/pie_prio_pick.sv
module pie_prio_pick #(
  parameter int unsigned N  = pie_pkg::DEF_SRCS,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  req_vec,
  output logic [IW-1:0] idx,
  output logic          any
);
  // Scan from the lowest-priority end so the lowest index is written last.
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_vec[i]) idx = IW'(i);
    end
  end

  assign any = |req_vec;
endmodule

// File: rtl/pie_group.sv
module pie_group #(
  parameter int unsigned SRCS = pie_pkg::DEF_SRCS,
  localparam int unsigned SW  = $clog2(SRCS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SRCS-1:0] pulse,
  input  logic            en_we,
  input  logic [SRCS-1:0] en_data,
  input  logic            ack_w1c,
  input  logic            fetch_hit,
  output logic [SRCS-1:0] flags,
  output logic [SRCS-1:0] enables,
  output logic            ack,
  output logic            req,
  output logic [SW-1:0]   win
);
  logic [SRCS-1:0] flag_q, flag_d, en_q, live, clr_mask, low_mask;
  logic            flag_ce, ack_q, ack_d, ack_ce, req_q, req_d, req_ce;
  logic [SW-1:0]   pick_idx;
  logic            live_any, fwd;

  assign live = flag_q & en_q;

  pie_prio_pick #(.N(SRCS)) u_pick (
    .req_vec (live),
    .idx     (pick_idx),
    .any     (live_any)
  );

  // Fall back to source 0 when nothing is both flagged and enabled.
  assign win = live_any ? pick_idx : '0;
  assign fwd = live_any && !ack_q;

  always_comb begin
    clr_mask = '0;
    if (fetch_hit) clr_mask[win] = 1'b1;
    flag_d  = (flag_q & ~clr_mask) | pulse;
    flag_ce = (|pulse) || fetch_hit;
  end

  always_comb begin
    ack_ce = fwd || ack_w1c;
    ack_d  = fwd ? 1'b1 : 1'b0;
    req_ce = fwd || fetch_hit;
    req_d  = fwd ? 1'b1 : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      en_q   <= '0;
      ack_q  <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      if (flag_ce) flag_q <= flag_d;
      if (en_we)   en_q   <= en_data;
      if (ack_ce)  ack_q  <= ack_d;
      if (req_ce)  req_q  <= req_d;
    end
  end

  assign flags   = flag_q;
  assign enables = en_q;
  assign ack     = ack_q;
  assign req     = req_q;

  // ---------------------------------------------------------------------------
  // Assertions
  // ---------------------------------------------------------------------------
  always_comb low_mask = (SRCS'(1) << pick_idx) - SRCS'(1);

  a_r3_rise_needs_live: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_q) |-> $past(live_any));
  a_r4_lock_with_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_q) |-> ack_q);
  a_r4_no_rise_locked: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_q) |-> !$past(ack_q));
  a_r5_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_w1c && !fwd) |=> !ack_q);
  a_r6_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !fetch_hit) |=> req_q);
  a_r7_top_priority: assert property (@(posedge clk) disable iff (!rst_n)
    live_any |-> (live[pick_idx] && ((live & low_mask) == '0)));
  a_r8_fallback_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_hit && !live_any && !pulse[0]) |=> !flag_q[0]);
  a_r9_clear_winner: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_hit && live_any && !pulse[pick_idx]) |=> !flag_q[$past(pick_idx)]);
  a_r10_pulse_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|pulse) |=> ((flag_q & $past(pulse)) == $past(pulse)));
endmodule

// File: rtl/grp_irq_expander.sv
module grp_irq_expander #(
  parameter int unsigned NUM_GROUPS = pie_pkg::DEF_GROUPS,
  parameter int unsigned SRCS       = pie_pkg::DEF_SRCS,
  localparam int unsigned GW = $clog2(NUM_GROUPS),
  localparam int unsigned SW = $clog2(SRCS),
  localparam int unsigned VW = GW + SW,
  localparam int unsigned NL = NUM_GROUPS * SRCS
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NL-1:0]         irq_pulse,
  input  logic                  en_we,
  input  logic [GW-1:0]         en_grp,
  input  logic [SRCS-1:0]       en_data,
  input  logic [NUM_GROUPS-1:0] ack_clr,
  input  logic                  fetch_stb,
  input  logic [GW-1:0]         fetch_grp,
  output logic [VW-1:0]         vec_out,
  output logic [NUM_GROUPS-1:0] cpu_irq,
  input  logic [GW-1:0]         rd_grp,
  output logic [SRCS-1:0]       rd_flags,
  output logic [SRCS-1:0]       rd_enables,
  output logic                  rd_ack
);
  logic                  rst_sync_n;
  logic [SRCS-1:0]       flags_a [NUM_GROUPS];
  logic [SRCS-1:0]       ens_a   [NUM_GROUPS];
  logic [SW-1:0]         win_a   [NUM_GROUPS];
  logic [NUM_GROUPS-1:0] ack_v;
  logic [NUM_GROUPS-1:0] fetch_hit;
  logic [NUM_GROUPS-1:0] en_hit;
  logic [SW-1:0]         vec_src;

  pie_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    assign fetch_hit[g] = fetch_stb && (fetch_grp == GW'(g));
    assign en_hit[g]    = en_we && (en_grp == GW'(g));

    pie_group #(.SRCS(SRCS)) u_group (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .pulse     (irq_pulse[g*SRCS +: SRCS]),
      .en_we     (en_hit[g]),
      .en_data   (en_data),
      .ack_w1c   (ack_clr[g]),
      .fetch_hit (fetch_hit[g]),
      .flags     (flags_a[g]),
      .enables   (ens_a[g]),
      .ack       (ack_v[g]),
      .req       (cpu_irq[g]),
      .win       (win_a[g])
    );
  end

  always_comb begin
    vec_src    = '0;
    rd_flags   = '0;
    rd_enables = '0;
    rd_ack     = 1'b0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (fetch_grp == GW'(g)) vec_src = win_a[g];
      if (rd_grp == GW'(g)) begin
        rd_flags   = flags_a[g];
        rd_enables = ens_a[g];
        rd_ack     = ack_v[g];
      end
    end
  end

  assign vec_out = {fetch_grp, vec_src};

  a_r6_fetch_drops_req: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((|(fetch_hit & cpu_irq)) && ((fetch_hit & ack_v) == fetch_hit))
      |=> ((cpu_irq & $past(fetch_hit)) == '0));
endmodule

// File: tb/tb_grp_irq_expander.sv
`timescale 1ns/1ps
module tb_grp_irq_expander;
  localparam int NG = 12;
  localparam int NS = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [95:0]   irq_pulse;
  logic          en_we;
  logic [3:0]    en_grp;
  logic [7:0]    en_data;
  logic [11:0]   ack_clr;
  logic          fetch_stb;
  logic [3:0]    fetch_grp;
  logic [6:0]    vec_out;
  logic [11:0]   cpu_irq;
  logic [3:0]    rd_grp;
  logic [7:0]    rd_flags, rd_enables;
  logic          rd_ack;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;
  logic [6:0] exp_q[$];
  string      tag_q[$];
  event       fetch_ev;

  always #2 clk = ~clk;

  grp_irq_expander dut (
    .clk(clk), .rst_n(rst_n), .irq_pulse(irq_pulse), .en_we(en_we),
    .en_grp(en_grp), .en_data(en_data), .ack_clr(ack_clr),
    .fetch_stb(fetch_stb), .fetch_grp(fetch_grp), .vec_out(vec_out),
    .cpu_irq(cpu_irq), .rd_grp(rd_grp), .rd_flags(rd_flags),
    .rd_enables(rd_enables), .rd_ack(rd_ack)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  // Monitor: pops the expected vector for each fetch and compares it.
  initial begin
    forever begin
      @(fetch_ev);
      chk(tag_q.pop_front(), {25'd0, vec_out}, {25'd0, exp_q.pop_front()});
    end
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic pulse_bits(logic [95:0] m);
    irq_pulse = m; tick(); irq_pulse = '0;
  endtask

  task automatic en_write(int g, logic [7:0] d);
    en_we = 1; en_grp = 4'(g); en_data = d; tick(); en_we = 0;
  endtask

  task automatic ack_write(logic [11:0] m);
    ack_clr = m; tick(); ack_clr = '0;
  endtask

  task automatic fetch(int g, int s, string req, logic [95:0] also_pulse = '0);
    fetch_grp = 4'(g); fetch_stb = 1; irq_pulse = also_pulse;
    #1;
    exp_q.push_back({4'(g), 3'(s)});
    tag_q.push_back(req);
    -> fetch_ev;
    tick();
    fetch_stb = 0; irq_pulse = '0;
  endtask

  task automatic rd(int g);
    rd_grp = 4'(g); #1;
  endtask

  function automatic logic [95:0] bitm(int g, int s);
    return 96'(1) << (g*NS + s);
  endfunction

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 0; irq_pulse = '0; en_we = 0; en_grp = '0; en_data = '0;
    ack_clr = '0; fetch_stb = 0; fetch_grp = '0; rd_grp = '0;
    repeat (3) tick();
    rst_n = 1;
    repeat (3) tick();

    // R1 reset state
    chk("R1 irq", cpu_irq, 0);
    rd(0); chk("R1 flags", rd_flags, 0); chk("R1 en", rd_enables, 0); chk("R1 ack", rd_ack, 0);

    // R2/R3: flag set without enable, no request
    pulse_bits(bitm(2, 3));
    rd(2); chk("R2 flag set", rd_flags, 8'h08);
    tick(); tick();
    chk("R3 no irq unenabled", cpu_irq, 0);

    // R6/R4: enable raises request and lockout
    en_write(2, 8'h08);
    tick();
    chk("R6 irq rises", cpu_irq, 12'h004);
    rd(2); chk("R4 lock set", rd_ack, 1);
    tick();
    chk("R6 irq held", cpu_irq, 12'h004);

    // R7/R9 fetch
    fetch(2, 3, "R7 vec g2s3");
    chk("R6 irq drops on fetch", cpu_irq, 0);
    rd(2); chk("R9 flag cleared", rd_flags, 0);

    // R4 lockout holds off new request; R5 clearing
    pulse_bits(bitm(2, 3));
    tick(); tick();
    chk("R4 locked no irq", cpu_irq, 0);
    ack_write(12'hFFB);
    rd(2); chk("R5 other bits no effect", rd_ack, 1);
    ack_write(12'h004);
    rd(2); chk("R5 lock cleared", rd_ack, 0);
    tick();
    chk("R5 irq after clear", cpu_irq, 12'h004);
    fetch(2, 3, "R7 vec g2s3 again");

    // R7 priority, R9 others kept
    en_write(5, 8'hFF);
    pulse_bits(bitm(5, 6) | bitm(5, 1));
    tick();
    chk("R6 irq g5", cpu_irq[5], 1);
    fetch(5, 1, "R7 prio g5s1");
    rd(5); chk("R9 other flag kept", rd_flags, 8'h40);
    ack_write(12'h020);
    tick();
    chk("R5 rearm g5", cpu_irq[5], 1);
    fetch(5, 6, "R7 prio g5s6");
    rd(5); chk("R9 group empty", rd_flags, 0);

    // R8 fallback
    pulse_bits(bitm(7, 0) | bitm(7, 2));
    tick();
    chk("R3 g7 no irq", cpu_irq[7], 0);
    fetch(7, 0, "R8 fallback vec");
    rd(7); chk("R8 fallback clears src0", rd_flags, 8'h04);

    // R10 pulse wins over fetch clear
    pulse_bits(bitm(9, 4));
    fetch(9, 0, "R8 fallback g9", bitm(9, 0));
    rd(9); chk("R10 pulse wins", rd_flags, 8'h11);

    // Last group, lowest priority source
    en_write(11, 8'h80);
    pulse_bits(bitm(11, 7));
    tick();
    chk("R6 irq g11", cpu_irq, 12'h800);
    fetch(11, 7, "R7 vec g11s7");

    // R11 enable write isolation
    en_write(0, 8'hA5);
    rd(0); chk("R11 en g0", rd_enables, 8'hA5);
    rd(5); chk("R11 en g5 kept", rd_enables, 8'hFF);
    rd(2); chk("R11 en g2 kept", rd_enables, 8'h08);

    tick();
    finish_run();
  end
endmodule